// File: doc/BRIEF.md
# Leaf Bucket Rule Matcher

This block finishes a packet lookup once a decision tree has narrowed the search down to one leaf. It is given a leaf index and a packet header made of two 32-bit addresses and two 16-bit ports. It walks through the rule pointers stored for that leaf and tests each rule the pointers name against the header. The address fields of a rule are compared under a mask. The port fields are compared against an inclusive lower and upper bound.

The bucket of each leaf is spread over `LANES` parallel lanes. Each lane has its own pointer table, its own copy of the rule table and its own comparator, so `LANES` rules are tested in each cycle. A lookup takes `BUCKET/LANES` cycles. It ends with a one-cycle done pulse, together with a hit flag and the ID of the matching rule with the lowest ID. That result stays on the outputs until the next lookup completes.

The pointer and rule tables are written through plain write ports.

Top module: `leaf_rule_matcher`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `hit_o` are low, `rule_id_o` is 0, and every pointer slot holds the null code.
- R2: An address field matches when `(hdr ^ rule_value) & rule_mask` is zero. A mask bit of 0 makes that bit position a don't-care.
- R3: A port field matches when `low <= port <= high`, with both bounds inclusive. A rule matches only when all four fields match.
- R4: The all-ones pointer code (`NUM_RULES-1`) marks an empty slot. An empty slot never produces a match, whatever rule is stored at that index.
- R5: When several rules in the bucket match, the reported ID is the smallest of them, whichever lane and scan cycle each one was found in.
- R6: A `start_i` sampled while idle begins a scan. `busy_o` stays high for exactly `BUCKET/LANES` cycles. `done_o` is high for one cycle, on the cycle after the last scan cycle, and `busy_o` is low at that point.
- R7: `hit_o` and `rule_id_o` change only together with `done_o`, and they hold until the next done. On a miss, `rule_id_o` is 0.
- R8: A `start_i` that arrives while `busy_o` is high is ignored. The scan in progress completes unchanged and no second done follows.
- R9: The leaf index and the header are captured on the accepted start. Changes to those inputs during the scan have no effect on the result.
- R10: A rule write stores `rule_data_i` at index `rule_addr_i` in the rule table of every lane. The record is packed from the most significant bit down as follows: source address [191:160], destination address [159:128], source mask [127:96], destination mask [95:64], source port low [63:48], source port high [47:32], destination port low [31:16], destination port high [15:0]. Bucket slot k of leaf L sits in lane `k % LANES`, at row `L*(BUCKET/LANES) + k/LANES` of that lane's pointer table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a lookup |
| leaf_i | input | LEAF_W | Leaf index to scan |
| src_addr_i | input | 32 | Header source address |
| dst_addr_i | input | 32 | Header destination address |
| src_port_i | input | 16 | Header source port |
| dst_port_i | input | 16 | Header destination port |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle completion pulse |
| hit_o | output | 1 | At least one rule matched |
| rule_id_o | output | PTR_W | Winning rule ID (0 on a miss) |
| ptr_we_i | input | 1 | Pointer table write enable |
| ptr_lane_i | input | LANE_W | Lane selected by a pointer write |
| ptr_row_i | input | ROW_W | Pointer table row |
| ptr_data_i | input | PTR_W | Rule pointer to store |
| rule_we_i | input | 1 | Rule table write enable |
| rule_addr_i | input | PTR_W | Rule index |
| rule_data_i | input | 192 | Packed rule record |

## Verification
The assertions assume that no table write overlaps a scan. The tables are read combinationally in every scan cycle, so a write during a scan could change a lane result while the lookup is in flight. The bench therefore loads all rules and pointers before the first lookup and never writes while `busy_o` is high. The assertions also assume that `leaf_i` stays below `NUM_LEAVES`. The stimulus only uses leaf indices 0 to 3 of the default eight.

// File: rtl/lrm_pkg.sv
package lrm_pkg;
  localparam int ADDR_W = 32;
  localparam int PORT_W = 16;

  typedef struct packed {
    logic [ADDR_W-1:0] src_addr;
    logic [ADDR_W-1:0] dst_addr;
    logic [ADDR_W-1:0] src_mask;
    logic [ADDR_W-1:0] dst_mask;
    logic [PORT_W-1:0] sp_lo;
    logic [PORT_W-1:0] sp_hi;
    logic [PORT_W-1:0] dp_lo;
    logic [PORT_W-1:0] dp_hi;
  } rule_t;

  typedef struct packed {
    logic [ADDR_W-1:0] src_addr;
    logic [ADDR_W-1:0] dst_addr;
    logic [PORT_W-1:0] src_port;
    logic [PORT_W-1:0] dst_port;
  } hdr_t;

  localparam int RULE_W = $bits(rule_t);
  localparam int HDR_W  = $bits(hdr_t);
endpackage

// File: rtl/lrm_rule_cmp.sv
module lrm_rule_cmp
  import lrm_pkg::*;
(
  input  rule_t rule_i,
  input  hdr_t  hdr_i,
  output logic  match_o
);
  logic src_ok, dst_ok, sp_ok, dp_ok;

  always_comb begin
    src_ok  = ((hdr_i.src_addr ^ rule_i.src_addr) & rule_i.src_mask) == '0;
    dst_ok  = ((hdr_i.dst_addr ^ rule_i.dst_addr) & rule_i.dst_mask) == '0;
    sp_ok   = (hdr_i.src_port >= rule_i.sp_lo) && (hdr_i.src_port <= rule_i.sp_hi);
    dp_ok   = (hdr_i.dst_port >= rule_i.dp_lo) && (hdr_i.dst_port <= rule_i.dp_hi);
    match_o = src_ok && dst_ok && sp_ok && dp_ok;
  end
endmodule

// File: rtl/lrm_lane.sv
module lrm_lane
  import lrm_pkg::*;
#(
  parameter int NUM_RULES = 32,
  parameter int ROWS      = 32,
  localparam int PTR_W    = $clog2(NUM_RULES),
  localparam int ROW_W    = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ptr_we_i,
  input  logic [ROW_W-1:0] ptr_row_i,
  input  logic [PTR_W-1:0] ptr_data_i,
  input  logic             rule_we_i,
  input  logic [PTR_W-1:0] rule_addr_i,
  input  rule_t            rule_data_i,
  input  logic [ROW_W-1:0] rd_row_i,
  input  hdr_t             hdr_i,
  output logic             match_o,
  output logic [PTR_W-1:0] id_o
);
  localparam logic [PTR_W-1:0] NULL_PTR = '1;

  logic [PTR_W-1:0] ptr_mem [ROWS];
  rule_t            rule_mem [NUM_RULES];
  logic [PTR_W-1:0] cur_ptr;
  rule_t            cur_rule;
  logic             cmp_match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < ROWS; r++) ptr_mem[r] <= NULL_PTR;
    end else if (ptr_we_i) begin
      ptr_mem[ptr_row_i] <= ptr_data_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rule_we_i) rule_mem[rule_addr_i] <= rule_data_i;
  end

  assign cur_ptr  = ptr_mem[rd_row_i];
  assign cur_rule = rule_mem[cur_ptr];

  lrm_rule_cmp u_cmp (
    .rule_i  (cur_rule),
    .hdr_i   (hdr_i),
    .match_o (cmp_match)
  );

  // empty slot masks the comparator
  assign match_o = cmp_match && (cur_ptr != NULL_PTR);
  assign id_o    = cur_ptr;

  p_null_skip_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_ptr == NULL_PTR) |-> !match_o);

  p_port_bounds_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> (hdr_i.src_port >= cur_rule.sp_lo && hdr_i.src_port <= cur_rule.sp_hi &&
                 hdr_i.dst_port >= cur_rule.dp_lo && hdr_i.dst_port <= cur_rule.dp_hi));

  p_prefix_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> (((hdr_i.src_addr ^ cur_rule.src_addr) & cur_rule.src_mask) == '0));
endmodule

// File: rtl/lrm_prio_merge.sv
module lrm_prio_merge #(
  parameter int LANES = 2,
  parameter int PTR_W = 5
) (
  input  logic [LANES-1:0]            lane_vld_i,
  input  logic [LANES-1:0][PTR_W-1:0] lane_id_i,
  input  logic                        acc_vld_i,
  input  logic [PTR_W-1:0]            acc_id_i,
  output logic                        vld_o,
  output logic [PTR_W-1:0]            id_o
);
  always_comb begin
    vld_o = acc_vld_i;
    id_o  = acc_vld_i ? acc_id_i : '0;
    for (int l = 0; l < LANES; l++) begin
      if (lane_vld_i[l] && (!vld_o || lane_id_i[l] < id_o)) begin
        vld_o = 1'b1;
        id_o  = lane_id_i[l];
      end
    end
  end
endmodule

// File: rtl/leaf_rule_matcher.sv
module leaf_rule_matcher
  import lrm_pkg::*;
#(
  parameter int NUM_RULES  = 32,
  parameter int NUM_LEAVES = 8,
  parameter int BUCKET     = 8,
  parameter int LANES      = 2,
  localparam int SCAN      = BUCKET / LANES,
  localparam int ROWS      = NUM_LEAVES * SCAN,
  localparam int PTR_W     = $clog2(NUM_RULES),
  localparam int LEAF_W    = (NUM_LEAVES > 1) ? $clog2(NUM_LEAVES) : 1,
  localparam int ROW_W     = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int LANE_W    = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int CNT_W     = (SCAN > 1) ? $clog2(SCAN) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LEAF_W-1:0] leaf_i,
  input  logic [31:0]       src_addr_i,
  input  logic [31:0]       dst_addr_i,
  input  logic [15:0]       src_port_i,
  input  logic [15:0]       dst_port_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              hit_o,
  output logic [PTR_W-1:0]  rule_id_o,
  input  logic              ptr_we_i,
  input  logic [LANE_W-1:0] ptr_lane_i,
  input  logic [ROW_W-1:0]  ptr_row_i,
  input  logic [PTR_W-1:0]  ptr_data_i,
  input  logic              rule_we_i,
  input  logic [PTR_W-1:0]  rule_addr_i,
  input  logic [191:0]      rule_data_i
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SCAN - 1);

  logic              busy_q, done_q, res_hit_q;
  logic [PTR_W-1:0]  res_id_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [LEAF_W-1:0] leaf_q;
  hdr_t              hdr_q;
  logic              acc_vld_q;
  logic [PTR_W-1:0]  acc_id_q;
  logic [ROW_W-1:0]  rd_row;
  logic              mrg_vld;
  logic [PTR_W-1:0]  mrg_id;

  logic [LANES-1:0]            lane_match;
  logic [LANES-1:0][PTR_W-1:0] lane_id;

  assign rd_row = ROW_W'(int'(leaf_q) * SCAN + int'(cnt_q));

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic lane_ptr_we;
    assign lane_ptr_we = ptr_we_i && (ptr_lane_i == LANE_W'(l));

    lrm_lane #(
      .NUM_RULES (NUM_RULES),
      .ROWS      (ROWS)
    ) u_lane (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .ptr_we_i    (lane_ptr_we),
      .ptr_row_i   (ptr_row_i),
      .ptr_data_i  (ptr_data_i),
      .rule_we_i   (rule_we_i),
      .rule_addr_i (rule_addr_i),
      .rule_data_i (rule_t'(rule_data_i)),
      .rd_row_i    (rd_row),
      .hdr_i       (hdr_q),
      .match_o     (lane_match[l]),
      .id_o        (lane_id[l])
    );

    p_win_min_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_q && lane_match[l]) |-> (mrg_vld && mrg_id <= lane_id[l]));
  end

  lrm_prio_merge #(
    .LANES (LANES),
    .PTR_W (PTR_W)
  ) u_merge (
    .lane_vld_i (lane_match),
    .lane_id_i  (lane_id),
    .acc_vld_i  (acc_vld_q),
    .acc_id_i   (acc_id_q),
    .vld_o      (mrg_vld),
    .id_o       (mrg_id)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      cnt_q     <= '0;
      leaf_q    <= '0;
      hdr_q     <= '0;
      acc_vld_q <= 1'b0;
      acc_id_q  <= '0;
      res_hit_q <= 1'b0;
      res_id_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q    <= 1'b1;
          cnt_q     <= '0;
          leaf_q    <= leaf_i;
          hdr_q     <= '{src_addr: src_addr_i, dst_addr: dst_addr_i,
                         src_port: src_port_i, dst_port: dst_port_i};
          acc_vld_q <= 1'b0;
          acc_id_q  <= '0;
        end
      end else begin
        acc_vld_q <= mrg_vld;
        acc_id_q  <= mrg_id;
        if (cnt_q == LAST) begin
          busy_q    <= 1'b0;
          done_q    <= 1'b1;
          res_hit_q <= mrg_vld;
          res_id_q  <= mrg_vld ? mrg_id : '0;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign hit_o     = res_hit_q;
  assign rule_id_o = res_id_q;

  p_done_end_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  p_res_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable({hit_o, rule_id_o}));

  p_miss_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (rule_id_o == '0));

  p_busy_ignore_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i && cnt_q != LAST) |=> (busy_q && cnt_q == $past(cnt_q) + CNT_W'(1)));

  p_leaf_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q)) |-> ($stable(leaf_q) && $stable(hdr_q)));
endmodule

// File: tb/leaf_rule_matcher_bench.sv
`timescale 1ns/1ps
module leaf_rule_matcher_bench;
  localparam int NR = 32, NL = 8, BK = 8, LN = 2;
  localparam int SC = BK / LN;
  localparam int NULLP = NR - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] leaf = '0;
  logic [31:0] src = '0, dst = '0;
  logic [15:0] sp = '0, dp = '0;
  logic busy, done, hit;
  logic [4:0] rid;
  logic ptr_we = 1'b0, rule_we = 1'b0;
  logic [0:0] ptr_lane = '0;
  logic [4:0] ptr_row = '0, ptr_data = '0, rule_addr = '0;
  logic [191:0] rule_data = '0;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [191:0] rule_sh [NR];
  int ptr_sh [NL][BK];
  logic [5:0] exp_q [$];

  always #2.5 clk = ~clk;

  leaf_rule_matcher u_leaf_rule_matcher (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .leaf_i(leaf),
    .src_addr_i(src), .dst_addr_i(dst), .src_port_i(sp), .dst_port_i(dp),
    .busy_o(busy), .done_o(done), .hit_o(hit), .rule_id_o(rid),
    .ptr_we_i(ptr_we), .ptr_lane_i(ptr_lane), .ptr_row_i(ptr_row), .ptr_data_i(ptr_data),
    .rule_we_i(rule_we), .rule_addr_i(rule_addr), .rule_data_i(rule_data)
  );

  task automatic check(input bit ok, input string rq, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  // monitor: pops expected result on every done pulse
  always @(negedge clk) begin
    if (rst_n && done && !finished) begin
      if (exp_q.size() == 0) check(1'b0, "R8 unexpected done", 1, 0);
      else begin
        logic [5:0] e;
        e = exp_q.pop_front();
        check({hit, rid} == e, "R5 result", {hit, rid}, e);
      end
    end
  end

  function automatic logic [191:0] mk(input logic [31:0] s, input logic [31:0] d,
      input logic [31:0] sm, input logic [31:0] dm, input logic [15:0] spl,
      input logic [15:0] sph, input logic [15:0] dpl, input logic [15:0] dph);
    return {s, d, sm, dm, spl, sph, dpl, dph};
  endfunction

  function automatic bit rmatch(input logic [191:0] r, input logic [31:0] s,
      input logic [31:0] d, input logic [15:0] a, input logic [15:0] b);
    return (((s ^ r[191:160]) & r[127:96]) == 0) && (((d ^ r[159:128]) & r[95:64]) == 0) &&
           a >= r[63:48] && a <= r[47:32] && b >= r[31:16] && b <= r[15:0];
  endfunction

  function automatic logic [5:0] model(input int lf, input logic [31:0] s,
      input logic [31:0] d, input logic [15:0] a, input logic [15:0] b);
    int best = -1;
    for (int k = 0; k < BK; k++) begin
      int p = ptr_sh[lf][k];
      if (p != NULLP && rmatch(rule_sh[p], s, d, a, b) && (best < 0 || p < best)) best = p;
    end
    return (best < 0) ? 6'd0 : {1'b1, 5'(best)};
  endfunction

  task automatic wr_rule(input int id, input logic [191:0] r);
    @(negedge clk);
    rule_we = 1'b1; rule_addr = 5'(id); rule_data = r;
    @(negedge clk);
    rule_we = 1'b0;
    rule_sh[id] = r;
  endtask

  // R10 slot mapping: lane k%LN, row leaf*SC + k/LN
  task automatic wr_slot(input int lf, input int k, input int id);
    @(negedge clk);
    ptr_we = 1'b1; ptr_lane = 1'(k % LN); ptr_row = 5'(lf * SC + k / LN); ptr_data = 5'(id);
    @(negedge clk);
    ptr_we = 1'b0;
    ptr_sh[lf][k] = id;
  endtask

  task automatic lookup(input int lf, input logic [31:0] s, input logic [31:0] d,
      input logic [15:0] a, input logic [15:0] b, input bit disturb);
    logic [5:0] e;
    e = model(lf, s, d, a, b);
    exp_q.push_back(e);
    @(negedge clk);
    leaf = 3'(lf); src = s; dst = d; sp = a; dp = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R6 busy after start", busy, 1);
    if (disturb) begin
      // R8/R9: new start and new header while busy
      start = 1'b1; leaf = 3'd2; src = ~s; dst = ~d; sp = ~a; dp = ~b;
    end
    for (int i = 1; i < SC; i++) begin
      @(negedge clk);
      if (i == SC - 2) start = 1'b0;
    end
    start = 1'b0;
    check(done == 1'b0 && busy == 1'b1, "R6 no early done", {busy, done}, 2'b10);
    @(negedge clk);
    check(done == 1'b1 && busy == 1'b0, "R6 done pulse", {busy, done}, 2'b01);
    @(negedge clk);
    check(done == 1'b0 && {hit, rid} == e, "R7 result held", {done, hit, rid}, {1'b0, e});
  endtask

  initial begin
    for (int l = 0; l < NL; l++) for (int k = 0; k < BK; k++) ptr_sh[l][k] = NULLP;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check({busy, done, hit, rid} == 0, "R1 reset state", {busy, done, hit, rid}, 0);

    wr_rule(3,  mk(32'h0A010000, 0, 32'hFFFF0000, 0, 0, 16'hFFFF, 80, 80));
    wr_rule(5,  mk(0, 32'hC0A80000, 0, 32'hFFFFFF00, 1000, 2000, 0, 16'hFFFF));
    wr_rule(9,  mk(0, 0, 0, 0, 0, 16'hFFFF, 0, 16'hFFFF));
    wr_rule(12, mk(32'h0A010203, 0, 32'hFFFFFFFF, 0, 0, 16'hFFFF, 80, 80));
    wr_rule(7,  mk(0, 0, 0, 0, 0, 16'hFFFF, 0, 16'hFFFF));
    wr_rule(14, mk(0, 0, 0, 0, 0, 16'hFFFF, 0, 16'hFFFF));
    wr_rule(20, mk(0, 0, 0, 0, 0, 16'hFFFF, 0, 16'hFFFF));
    wr_rule(NULLP, mk(0, 0, 0, 0, 0, 16'hFFFF, 0, 16'hFFFF));
    wr_slot(0, 0, 12); wr_slot(0, 6, 9); wr_slot(0, 7, 3);
    wr_slot(1, 2, 5);  wr_slot(1, 5, 12);
    wr_slot(3, 0, 20); wr_slot(3, 1, 14); wr_slot(3, 7, 7);

    lookup(0, 32'h0A010203, 32'h01020304, 5, 80, 0);     // R5 three matches -> 3
    lookup(0, 32'h0A010999, 32'h0, 5, 80, 0);            // R2 prefix /16 only
    lookup(0, 32'h0B000000, 32'h0, 5, 80, 0);            // R2 only catch-all 9
    lookup(1, 32'h0, 32'hC0A80012, 1000, 7, 0);          // R3 lower bound
    lookup(1, 32'h0, 32'hC0A800FF, 2000, 7, 0);          // R3 upper bound
    lookup(1, 32'h0, 32'hC0A80012, 999, 7, 0);           // R3 below -> miss
    lookup(1, 32'h0, 32'hC0A80012, 2001, 7, 0);          // R3 above -> miss
    lookup(1, 32'h0, 32'hC0A80112, 1500, 7, 0);          // R2 prefix mismatch
    lookup(2, 32'h0, 32'h0, 1, 1, 0);                    // R4 all slots null
    lookup(3, 32'h12345678, 32'h9ABCDEF0, 3, 4, 0);      // R5 across lanes/cycles -> 7
    lookup(0, 32'h0A010203, 32'h0, 5, 80, 1);            // R8 R9 disturbed scan
    for (int i = 0; i < SC + 2; i++) begin
      @(negedge clk);
      check(done == 1'b0, "R8 no second done", done, 0);
    end
    check(exp_q.size() == 0, "R6 all results seen", exp_q.size(), 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule